// File: doc/BRIEF.md
# Direct-Mapped Cache with Deferred Write-Hit Data Update

This block is a small direct-mapped data cache that sits between a CPU request port and a line-fill memory port. A read hit returns its word in the same cycle that the request is accepted: the direct-mapped lookup indexes the data array in parallel with the tag compare.

A write cannot touch the data array before its tag compare has confirmed a hit. The write is therefore split into two stages. In the request cycle the tag is checked and the CPU is released. The index, word offset and data are then held in a one-entry pending-write register, and that register updates the data array in the following cycle. A read of the word still sitting in the pending register gets the pending data by forwarding. Back-to-back write hits proceed at one per cycle.

On any miss the block stalls the CPU, fetches the whole line from memory, installs the tag and valid bit, and replays the held request. Writes update only the cache. Replacing a line discards any words written into it.

Top module: `wbc_cache`

## Requirements
- R1: A read that hits is accepted (cpu_ready high) in the cycle it is presented, and cpu_rdata carries the addressed word in that same cycle.
- R2: A write that hits is accepted in the cycle it is presented, with no stall cycle.
- R3: A read of the same word, issued in the cycle right after a write hit to it, returns the newly written data.
- R4: After the pending write has drained, later reads of that word return the written data.
- R5: Write hits issued on consecutive cycles are all accepted without stall. When two of them target the same word, the later data is what a following read returns.
- R6: On a miss, cpu_ready stays low and mem_req is raised with mem_addr equal to the line address (cpu_addr shifted right by OFF_W). mem_req and mem_addr hold until mem_ack. The held access is then replayed and completes as a hit. Word w of the line is mem_line[w*DATA_W +: DATA_W].
- R7: A write that misses first fills the line from memory and then writes its word. The other words of that line return their memory values.
- R8: Reset clears every valid bit and the pending write. After reset, cpu_ready and mem_req are low, and the first access misses.
- R9: A read of a different word in the same line as a pending write returns that word's array contents, not the pending data.
- R10: An access whose tag differs from the resident tag at the same index misses and replaces the line. Data written into the replaced line is lost, and a later access to it refetches from memory.
- R11: No memory request is raised during a cycle in which a CPU access is accepted. Every fill corresponds to exactly one miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | CPU request present; held until accepted |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address {tag, index, offset} |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request accepted at the next rising edge |
| cpu_rdata | output | DATA_W | Read data, valid while a read is accepted |
| mem_req | output | 1 | Line fill request |
| mem_addr | output | ADDR_W-OFF_W | Line address of the fill |
| mem_ack | input | 1 | Fill data present on mem_line this cycle |
| mem_line | input | DATA_W*2**OFF_W | Whole line returned by memory |

## Verification
The hardest state to reach from the ports is the one where the pending register holds a word that the data array does not yet have, and a read arrives in exactly that cycle. The stimulus gets there by issuing a read in the cycle directly after a write hit, with no idle cycle between them. It does this both for the same word, where forwarding must apply, and for a neighbouring word of the same line, where forwarding must not apply. Runs of consecutive writes to one word check that the last one wins. A conflicting tag at a shared index forces replacement and refetch.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_FILL = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/wbc_tag_array.sv
module wbc_tag_array #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] vld_d, vld_q;
    logic [TAG_W-1:0] tag_d [LINES];
    logic [TAG_W-1:0] tag_q [LINES];

    always_comb begin
        vld_d = vld_q;
        tag_d = tag_q;
        if (wr_en) begin
            vld_d[wr_idx] = 1'b1;
            tag_d[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
    end

    always_ff @(posedge clk) begin
        tag_q <= tag_d;
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/wbc_data_array.sv
module wbc_data_array #(
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic [IDX_W-1:0]              rd_idx,
    input  logic [OFF_W-1:0]              rd_off,
    output logic [DATA_W-1:0]             rd_word,
    input  logic                          fill_en,
    input  logic [IDX_W-1:0]              fill_idx,
    input  logic [DATA_W*(1<<OFF_W)-1:0]  fill_line,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [OFF_W-1:0]              wr_off,
    input  logic [DATA_W-1:0]             wr_word
);
    localparam int LINES = 1 << IDX_W;
    localparam int WORDS = 1 << OFF_W;

    logic [DATA_W-1:0] arr_d [LINES][WORDS];
    logic [DATA_W-1:0] arr_q [LINES][WORDS];
    logic [DATA_W-1:0] fill_word [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_slice
        assign fill_word[w] = fill_line[w*DATA_W +: DATA_W];
    end

    always_comb begin
        arr_d = arr_q;
        if (fill_en) begin
            arr_d[fill_idx] = fill_word;
        end
        if (wr_en) begin
            arr_d[wr_idx][wr_off] = wr_word;
        end
    end

    always_ff @(posedge clk) begin
        arr_q <= arr_d;
    end

    assign rd_word = arr_q[rd_idx][rd_off];
endmodule

// File: rtl/wbc_pend_buf.sv
module wbc_pend_buf #(
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [IDX_W-1:0]  cap_idx,
    input  logic [OFF_W-1:0]  cap_off,
    input  logic [DATA_W-1:0] cap_data,
    output logic              drain_en,
    output logic [IDX_W-1:0]  drain_idx,
    output logic [OFF_W-1:0]  drain_off,
    output logic [DATA_W-1:0] drain_data,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [OFF_W-1:0]  lk_off,
    output logic              lk_hit
);
    typedef struct packed {
        logic              v;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } pend_t;

    pend_t pend_d, pend_q;

    always_comb begin
        pend_d   = pend_q;
        pend_d.v = 1'b0;
        if (cap_en) begin
            pend_d.v    = 1'b1;
            pend_d.idx  = cap_idx;
            pend_d.off  = cap_off;
            pend_d.data = cap_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign drain_en   = pend_q.v;
    assign drain_idx  = pend_q.idx;
    assign drain_off  = pend_q.off;
    assign drain_data = pend_q.data;
    assign lk_hit     = pend_q.v && (pend_q.idx == lk_idx) && (pend_q.off == lk_off);
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             cpu_valid,
    input  logic                             cpu_we,
    input  logic [ADDR_W-1:0]                cpu_addr,
    input  logic [DATA_W-1:0]                cpu_wdata,
    output logic                             cpu_ready,
    output logic [DATA_W-1:0]                cpu_rdata,
    output logic                             mem_req,
    output logic [ADDR_W-OFF_W-1:0]          mem_addr,
    input  logic                             mem_ack,
    input  logic [DATA_W*(1<<OFF_W)-1:0]     mem_line
);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int LADDR_W = ADDR_W - OFF_W;

    typedef struct packed {
        ctl_state_e         state;
        logic [LADDR_W-1:0] line;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;
    logic              t_valid;
    logic [TAG_W-1:0]  t_tag;
    logic              tag_hit;
    logic              fill_en;
    logic              cap_en;
    logic              drain_en;
    logic [IDX_W-1:0]  drain_idx;
    logic [OFF_W-1:0]  drain_off;
    logic [DATA_W-1:0] drain_data;
    logic              fwd_hit;
    logic [DATA_W-1:0] arr_word;

    assign a_off = cpu_addr[OFF_W-1:0];
    assign a_idx = cpu_addr[OFF_W +: IDX_W];
    assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];

    assign tag_hit   = t_valid && (t_tag == a_tag);
    assign cpu_ready = cpu_valid && (ctl_q.state == ST_RUN) && tag_hit;
    assign cap_en    = cpu_ready && cpu_we;
    assign mem_req   = (ctl_q.state == ST_FILL);
    assign mem_addr  = ctl_q.line;
    assign fill_en   = mem_req && mem_ack;
    assign cpu_rdata = fwd_hit ? drain_data : arr_word;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (cpu_valid && !tag_hit) begin
                    ctl_d.state = ST_FILL;
                    ctl_d.line  = {a_tag, a_idx};
                end
            end
            ST_FILL: begin
                if (mem_ack) ctl_d.state = ST_RUN;
            end
            default: ctl_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{state: ST_RUN, line: '0};
        else        ctl_q <= ctl_d;
    end

    wbc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (a_idx),
        .rd_valid (t_valid),
        .rd_tag   (t_tag),
        .wr_en    (fill_en),
        .wr_idx   (ctl_q.line[IDX_W-1:0]),
        .wr_tag   (ctl_q.line[LADDR_W-1 -: TAG_W])
    );

    wbc_data_array #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_data (
        .clk       (clk),
        .rd_idx    (a_idx),
        .rd_off    (a_off),
        .rd_word   (arr_word),
        .fill_en   (fill_en),
        .fill_idx  (ctl_q.line[IDX_W-1:0]),
        .fill_line (mem_line),
        .wr_en     (drain_en),
        .wr_idx    (drain_idx),
        .wr_off    (drain_off),
        .wr_word   (drain_data)
    );

    wbc_pend_buf #(.IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .cap_idx    (a_idx),
        .cap_off    (a_off),
        .cap_data   (cpu_wdata),
        .drain_en   (drain_en),
        .drain_idx  (drain_idx),
        .drain_off  (drain_off),
        .drain_data (drain_data),
        .lk_idx     (a_idx),
        .lk_off     (a_off),
        .lk_hit     (fwd_hit)
    );
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cpu_valid,
    input logic                         cpu_we,
    input logic [ADDR_W-1:0]            cpu_addr,
    input logic [DATA_W-1:0]            cpu_wdata,
    input logic                         cpu_ready,
    input logic [DATA_W-1:0]            cpu_rdata,
    input logic                         mem_req,
    input logic [ADDR_W-OFF_W-1:0]      mem_addr,
    input logic                         mem_ack
);
    // R6: a fill request stays up, on a fixed line, until acknowledged
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R6: the CPU is held while a fill is outstanding
    p_stall_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R6: an acknowledged fill ends the request
    p_fill_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);

    // R11: an accepted access never starts a fill in the next cycle
    p_no_req_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready) |=> !mem_req);

    // R3: a read right after a write to the same word sees the new data
    p_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_we) |=>
        (!(cpu_valid && cpu_ready && !cpu_we && cpu_addr == $past(cpu_addr))
         || cpu_rdata == $past(cpu_wdata)));
endmodule

bind wbc_cache wbc_cache_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
) i_wbc_cache_chk (.*);

// File: tb/test_wbc_cache.sv
module test_wbc_cache;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;
    localparam int OFF_W  = 2;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int WORDS  = 1 << OFF_W;
    localparam int LINES  = 1 << IDX_W;
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int MEM_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_valid = 1'b0;
    logic cpu_we = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DATA_W-1:0] cpu_rdata;
    logic mem_req;
    logic [LADDR_W-1:0] mem_addr;
    logic mem_ack = 1'b0;
    logic [DATA_W*WORDS-1:0] mem_line = '0;

    int checks = 0;
    int fails = 0;
    int fills = 0;
    int lat = 0;
    logic [LADDR_W-1:0] exp_line = '0;

    typedef struct {
        logic [DATA_W-1:0] d;
        string             rq;
    } exp_t;
    exp_t exp_q[$];

    bit                ref_v [LINES];
    logic [TAG_W-1:0]  ref_t [LINES];
    logic [DATA_W-1:0] ref_d [LINES][WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    wbc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) i_wbc_cache (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_line(mem_line)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [LADDR_W-1:0] ln, input int w);
        return {8'hA5, ln, 14'h0, 2'(w)};
    endfunction

    function automatic logic [ADDR_W-1:0] mk(input int tg, input int ix, input int of);
        return {TAG_W'(tg), IDX_W'(ix), OFF_W'(of)};
    endfunction

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // memory model: acknowledges a fill after MEM_LAT cycles
    always begin
        @(posedge clk);
        #1;
        mem_ack = 1'b0;
        if (mem_req) begin
            lat++;
            if (lat == MEM_LAT) begin
                check(mem_addr == exp_line, "R6", "fill line address",
                      DATA_W'(mem_addr), DATA_W'(exp_line));
                for (int w = 0; w < WORDS; w++) mem_line[w*DATA_W +: DATA_W] = mem_word(mem_addr, w);
                mem_ack = 1'b1;
                fills++;
                lat = 0;
            end
        end
    end

    // monitor: compare read data at each accepted read
    always @(negedge clk) begin
        if (rst_n && cpu_valid && cpu_ready) begin
            check(!mem_req, "R11", "request during accept", DATA_W'(mem_req), 0);
            if (!cpu_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "scoreboard", "unexpected read", cpu_rdata, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cpu_rdata == e.d, e.rq, "read data", cpu_rdata, e.d);
                end
            end
        end
    end

    // driver: called positioned just after a rising edge; returns likewise
    task automatic access(input bit we, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] wd, input string rq);
        logic [IDX_W-1:0] ix;
        logic [OFF_W-1:0] of;
        logic [TAG_W-1:0] tg;
        bit miss;
        int want_fills;
        int waits;
        ix = a[OFF_W +: IDX_W];
        of = a[OFF_W-1:0];
        tg = a[ADDR_W-1 -: TAG_W];
        miss = !(ref_v[ix] && ref_t[ix] == tg);
        want_fills = fills + (miss ? 1 : 0);
        if (miss) begin
            ref_v[ix] = 1'b1;
            ref_t[ix] = tg;
            for (int w = 0; w < WORDS; w++) ref_d[ix][w] = mem_word(a[ADDR_W-1:OFF_W], w);
            exp_line = a[ADDR_W-1:OFF_W];
        end
        if (we) ref_d[ix][of] = wd;
        else exp_q.push_back('{d: ref_d[ix][of], rq: rq});
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        waits = 0;
        forever begin
            @(negedge clk);
            if (cpu_ready || waits > 100) break;
            waits++;
        end
        check(miss ? (waits > 0) : (waits == 0), rq, "stall cycles",
              DATA_W'(waits), DATA_W'(miss));
        check(fills == want_fills, rq, "fill count", DATA_W'(fills), DATA_W'(want_fills));
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        cpu_valid = 1'b0;
        cpu_we    = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) ref_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        check(cpu_ready == 1'b0, "R8", "ready after reset", DATA_W'(cpu_ready), 0);
        check(mem_req == 1'b0, "R8", "mem_req after reset", DATA_W'(mem_req), 0);
        @(posedge clk);
        #1;
        access(0, mk(1, 0, 2), 0, "R8");            // first access misses, R6 fill
        access(0, mk(1, 0, 3), 0, "R1");            // read hit
        access(1, mk(1, 0, 1), 32'h1111_2222, "R2"); // write hit, no stall
        access(0, mk(1, 0, 1), 0, "R3");            // forwarded from pending
        access(1, mk(1, 0, 0), 32'h3333_4444, "R2");
        access(0, mk(1, 0, 3), 0, "R9");            // same line, other word
        idle(2);
        access(0, mk(1, 0, 0), 0, "R4");            // drained into array
        access(0, mk(1, 0, 1), 0, "R4");
        access(1, mk(1, 0, 2), 32'hAAAA_0001, "R5");
        access(1, mk(1, 0, 2), 32'hBBBB_0002, "R5");
        access(1, mk(1, 0, 3), 32'hCCCC_0003, "R5");
        access(0, mk(1, 0, 2), 0, "R5");
        access(0, mk(1, 0, 3), 0, "R5");
        idle(1);
        access(1, mk(2, 1, 1), 32'hDDDD_0004, "R7"); // write miss
        access(0, mk(2, 1, 1), 0, "R7");
        access(0, mk(2, 1, 0), 0, "R7");
        access(0, mk(2, 1, 3), 0, "R7");
        access(0, mk(3, 0, 0), 0, "R10");           // conflict evicts tag 1
        access(0, mk(1, 0, 2), 0, "R10");           // refetched, written data lost
        access(0, mk(2, 1, 1), 0, "R10");           // other index untouched
        idle(2);
        check(exp_q.size() == 0, "R11", "scoreboard drained",
              DATA_W'(exp_q.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule